// File: doc/BRIEF.md
# Serial Address Shift Loader

This block places an address onto the parallel outputs of an external serial-in, parallel-out shift register chain. The chain has a storage latch, an active-low clear and an active-low output enable. A caller presents an address word and pulses a start strobe. The loader then works through a fixed sequence of line levels, with every step counted in clock cycles:

1. It disables the chain outputs.
2. It clears the chain.
3. It shifts the word in, least significant bit first, one bit for each rising edge of the shift clock.
4. It pulses the latch clock.
5. It re-enables the outputs.
6. After a settle delay it reports completion with a single-cycle pulse.

The step lengths are parameters. Their defaults are sized for a 125 MHz clock: three cycles (24 ns) for the clear pulse, three cycles for each half of the shift clock, and three cycles for the settle delay after the outputs are re-enabled. While a load is running, `busy_o` is high and any further start strobe has no effect. A synchronous reset stops a load at once and puts every line back to its idle level.

Top module: `sipo_addr_loader`

## Requirements
- R1: After reset, and whenever no load has run since reset, the lines are at their idle levels: `ser_o`=0, `sclk_o`=0, `rclk_o`=0, `clr_n_o`=1, `oe_n_o`=1, `busy_o`=0 and `done_o`=0.
- R2: A start strobe that is sampled while idle is accepted. From the next cycle `busy_o` is 1, `oe_n_o` is 1 and `rclk_o` is 0, and `clr_n_o` is held at 0 for exactly CLR_CYC (default 3) cycles.
- R3: Each load produces exactly ADDR_W rising edges on `sclk_o`. The bit driven on `ser_o` for rising edge n (counting from 0) is address bit n, so the least significant bit goes first. `ser_o` does not change while `sclk_o` is high.
- R4: For each bit, `sclk_o` is low for SCLK_LO_CYC (default 3) cycles with the bit already on `ser_o`, and then high for SCLK_HI_CYC (default 3) cycles. The first low phase starts in the cycle after the clear ends.
- R5: In the cycle after the last high phase, `rclk_o` goes to 1 while `oe_n_o` is still 1. `oe_n_o` falls only in a cycle where `rclk_o` is 1 and was also 1 in the cycle before.
- R6: `oe_n_o` is 0 for SETTLE_CYC (default 3) cycles before `done_o`. `done_o` is high for exactly one cycle, and `busy_o` falls in the cycle after it. With the defaults, `done_o` is high in cycle 104 after the accepting edge.
- R7: After a completed load, `oe_n_o` stays 0 and `rclk_o`, `sclk_o` and `ser_o` return to 0. These levels hold until the next accepted start or a reset.
- R8: A start strobe that arrives while `busy_o` is 1, including the cycle in which `done_o` is high, is ignored. The running load keeps its address and its timing, and no second load follows. A start in the first cycle after `busy_o` falls is accepted.
- R9: A synchronous reset in the middle of a load aborts it. In the next cycle every line is at its R1 idle level, and no `done_o` pulse follows.
- R10: When a load completes, a chain that shifts on each `sclk_o` rising edge (the new bit entering at the top and moving toward bit 0), is cleared by `clr_n_o` and copies to its outputs on the `rclk_o` rising edge, holds exactly the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; sampled on the rising edge |
| addr_i | input | ADDR_W | Address word, captured when a start is accepted |
| busy_o | output | 1 | High from the cycle after acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| ser_o | output | 1 | Serial data to the chain |
| sclk_o | output | 1 | Shift clock; the chain captures on its rising edge |
| rclk_o | output | 1 | Latch (storage) clock |
| clr_n_o | output | 1 | Active-low clear of the chain |
| oe_n_o | output | 1 | Active-low output enable of the chain |

## Verification
The completion pulse and a new start strobe can land in the same cycle. `busy_o` is still high during the `done_o` cycle, so that strobe has to be dropped, while a strobe one cycle later has to start a new load. The bench raises `start_i` with a different address exactly in the `done_o` cycle of one load. It then checks that the lines stay idle with `oe_n_o` low and that the chain model still holds the first address. A separate run raises a strobe in the first idle cycle and expects a full second load.

// File: rtl/sal_pkg.sv
package sal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_SLO,
      ST_SHI,
      ST_LATCH,
      ST_SETTLE,
      ST_DONE
   } sal_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sal_timer.sv
module sal_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sal_shreg.sv
module sal_shreg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              advance_i,
   output logic              bit_o,
   output logic              last_o
);
   localparam int BIT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(ADDR_W - 1);

   logic [ADDR_W-1:0] word_q;
   logic [BIT_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
         idx_q  <= '0;
      end else if (capture_i) begin
         word_q <= addr_i;
         idx_q  <= '0;
      end else if (advance_i) begin
         word_q <= {1'b0, word_q[ADDR_W-1:1]};
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign bit_o  = word_q[0];
   assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/sal_ctrl.sv
module sal_ctrl
   import sal_pkg::*;
#(
   parameter int CNT_W       = 2,
   parameter int CLR_CYC     = 3,
   parameter int SCLK_LO_CYC = 3,
   parameter int SCLK_HI_CYC = 3,
   parameter int SETTLE_CYC  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             tmr_exp_i,
   input  logic             last_bit_i,
   input  logic             bit_i,
   output logic             tmr_load_o,
   output logic [CNT_W-1:0] tmr_val_o,
   output logic             capture_o,
   output logic             advance_o,
   output logic             ser_o,
   output logic             sclk_o,
   output logic             rclk_o,
   output logic             clr_n_o,
   output logic             oe_n_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] CLR_LD = CNT_W'(CLR_CYC - 1);
   localparam logic [CNT_W-1:0] LO_LD  = CNT_W'(SCLK_LO_CYC - 1);
   localparam logic [CNT_W-1:0] HI_LD  = CNT_W'(SCLK_HI_CYC - 1);
   localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SETTLE_CYC - 1);

   sal_state_e state_q, state_d;
   logic       en_q;

   always_comb begin
      state_d    = state_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      capture_o  = 1'b0;
      advance_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            capture_o  = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = CLR_LD;
            state_d    = ST_CLEAR;
         end
         ST_CLEAR: if (tmr_exp_i) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = LO_LD;
            state_d    = ST_SLO;
         end
         ST_SLO: if (tmr_exp_i) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = HI_LD;
            state_d    = ST_SHI;
         end
         ST_SHI: if (tmr_exp_i) begin
            advance_o  = 1'b1;
            tmr_load_o = 1'b1;
            if (last_bit_i) begin
               tmr_val_o = '0;
               state_d   = ST_LATCH;
            end else begin
               tmr_val_o = LO_LD;
               state_d   = ST_SLO;
            end
         end
         ST_LATCH: begin
            tmr_load_o = 1'b1;
            tmr_val_o  = SET_LD;
            state_d    = ST_SETTLE;
         end
         ST_SETTLE: if (tmr_exp_i) state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         en_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture_o)
            en_q <= 1'b0;
         else if (state_q == ST_LATCH)
            en_q <= 1'b1;
      end
   end

   always_comb begin
      ser_o   = ((state_q == ST_SLO) || (state_q == ST_SHI)) ? bit_i : 1'b0;
      sclk_o  = (state_q == ST_SHI);
      rclk_o  = (state_q == ST_LATCH) || (state_q == ST_SETTLE) || (state_q == ST_DONE);
      clr_n_o = (state_q != ST_CLEAR);
      if (state_q == ST_IDLE)
         oe_n_o = ~en_q;
      else
         oe_n_o = ~((state_q == ST_SETTLE) || (state_q == ST_DONE));
      busy_o  = (state_q != ST_IDLE);
      done_o  = (state_q == ST_DONE);
   end
endmodule

// File: rtl/sipo_addr_loader.sv
module sipo_addr_loader #(
   parameter int ADDR_W      = 16,
   parameter int CLR_CYC     = 3,
   parameter int SCLK_LO_CYC = 3,
   parameter int SCLK_HI_CYC = 3,
   parameter int SETTLE_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              ser_o,
   output logic              sclk_o,
   output logic              rclk_o,
   output logic              clr_n_o,
   output logic              oe_n_o
);
   localparam int MAX_DLY = sal_pkg::max2(sal_pkg::max2(CLR_CYC, SCLK_LO_CYC),
                                          sal_pkg::max2(SCLK_HI_CYC, SETTLE_CYC));
   localparam int CNT_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("sipo_addr_loader: ADDR_W must be at least 2");
      end
      if (CLR_CYC < 1 || SCLK_LO_CYC < 1 || SCLK_HI_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_dly
         $error("sipo_addr_loader: every phase length must be at least one cycle");
      end
   endgenerate

   logic             tmr_load, tmr_exp;
   logic [CNT_W-1:0] tmr_val;
   logic             capture, advance, cur_bit, last_bit;

   sal_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_exp)
   );

   sal_shreg #(.ADDR_W(ADDR_W)) u_shreg (
      .clk       (clk),
      .rst       (rst),
      .capture_i (capture),
      .addr_i    (addr_i),
      .advance_i (advance),
      .bit_o     (cur_bit),
      .last_o    (last_bit)
   );

   sal_ctrl #(
      .CNT_W       (CNT_W),
      .CLR_CYC     (CLR_CYC),
      .SCLK_LO_CYC (SCLK_LO_CYC),
      .SCLK_HI_CYC (SCLK_HI_CYC),
      .SETTLE_CYC  (SETTLE_CYC)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .tmr_exp_i  (tmr_exp),
      .last_bit_i (last_bit),
      .bit_i      (cur_bit),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .capture_o  (capture),
      .advance_o  (advance),
      .ser_o      (ser_o),
      .sclk_o     (sclk_o),
      .rclk_o     (rclk_o),
      .clr_n_o    (clr_n_o),
      .oe_n_o     (oe_n_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
   parameter int ADDR_W = 16
) (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic ser_o,
   input logic sclk_o,
   input logic rclk_o,
   input logic clr_n_o,
   input logic oe_n_o
);
   localparam int EW = $clog2(ADDR_W + 1) + 1;

   logic [EW-1:0] edge_cnt;
   logic          sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         edge_cnt <= '0;
         sclk_q   <= 1'b0;
      end else begin
         sclk_q <= sclk_o;
         if (start_i && !busy_o)
            edge_cnt <= '0;
         else if (sclk_o && !sclk_q)
            edge_cnt <= edge_cnt + 1'b1;
      end
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (!ser_o && !sclk_o && !rclk_o && clr_n_o && !done_o));

   a_r2_clear_guarded: assert property (@(posedge clk) disable iff (rst)
      !clr_n_o |-> (oe_n_o && !rclk_o && !sclk_o && busy_o));

   a_r3_data_steady: assert property (@(posedge clk) disable iff (rst)
      sclk_o |-> $stable(ser_o));

   a_r3_edge_count: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (edge_cnt == EW'(ADDR_W)));

   a_r5_enable_after_latch: assert property (@(posedge clk) disable iff (rst)
      $fell(oe_n_o) |-> (rclk_o && $past(rclk_o)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (!done_o && !busy_o));

   a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !done_o) |=> busy_o);

   a_r9_reset_abort: assert property (@(posedge clk)
      rst |=> (!busy_o && !done_o && oe_n_o && clr_n_o && !sclk_o && !rclk_o && !ser_o));
endmodule

bind sipo_addr_loader sal_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sipo_addr_loader_tb.sv
module sipo_addr_loader_tb;
   localparam int CLK_PERIOD = 8;
   localparam int AW  = 16;
   localparam int CLR = 3;
   localparam int LO  = 3;
   localparam int HI  = 3;
   localparam int SET = 3;
   localparam int LB  = CLR + AW * (LO + HI);
   localparam int K_DONE = LB + SET + 2;
   localparam int K_END  = K_DONE + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic busy_o, done_o, ser_o, sclk_o, rclk_o, clr_n_o, oe_n_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [AW-1:0] exp_q[$];
   logic [AW-1:0] chain = '0;
   logic [AW-1:0] latched = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sipo_addr_loader u_dut (
      .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
      .busy_o(busy_o), .done_o(done_o), .ser_o(ser_o), .sclk_o(sclk_o),
      .rclk_o(rclk_o), .clr_n_o(clr_n_o), .oe_n_o(oe_n_o)
   );

   // behavioural model of the external chain
   always @(posedge sclk_o or negedge clr_n_o) begin
      if (!clr_n_o) chain <= '0;
      else          chain <= {ser_o, chain[AW-1:1]};
   end
   always @(posedge rclk_o) latched <= chain;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
      end
   endtask

   // scoreboard monitor: compare latched word at every completion
   always @(negedge clk) begin
      if (!rst && done_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected done", 32'(latched), 32'hFFFF_FFFF);
         end else begin
            logic [AW-1:0] e;
            e = exp_q.pop_front();
            chk(latched == e, "R10 latched address", 32'(latched), 32'(e));
         end
      end
   end

   function automatic logic [6:0] cur_lines();
      return {busy_o, done_o, ser_o, sclk_o, rclk_o, clr_n_o, oe_n_o};
   endfunction

   // expected {busy,done,ser,sclk,rclk,clr_n,oe_n} at negedge k after accept
   function automatic logic [6:0] exp_at(input int k, input logic [AW-1:0] a);
      if (k <= CLR) return 7'b1_0_0_0_0_0_1;
      if (k <= LB) begin
         int j, i, p;
         j = k - CLR - 1;
         i = j / (LO + HI);
         p = j % (LO + HI);
         return {1'b1, 1'b0, a[i], (p >= LO), 1'b0, 1'b1, 1'b1};
      end
      if (k == LB + 1)  return 7'b1_0_0_0_1_1_1;
      if (k < K_DONE)   return 7'b1_0_0_0_1_1_0;
      if (k == K_DONE)  return 7'b1_1_0_0_1_1_0;
      return 7'b0_0_0_0_0_1_0;
   endfunction

   function automatic string tag_at(input int k);
      if (k <= CLR)    return "R2 clear phase";
      if (k <= LB)     return "R4 shift phase (R3 bit order)";
      if (k == LB + 1) return "R5 latch";
      if (k <= K_DONE) return "R6 settle/done";
      return "R7 after done";
   endfunction

   task automatic run_traced(input logic [AW-1:0] a, input int inj_k, input logic [AW-1:0] inj_a);
      @(negedge clk);
      start_i = 1'b1; addr_i = a;
      exp_q.push_back(a);
      for (int k = 1; k <= K_END; k++) begin
         @(negedge clk);
         if (k == inj_k) begin start_i = 1'b1; addr_i = inj_a; end
         else            begin start_i = 1'b0; addr_i = ~a; end
         chk(cur_lines() == exp_at(k, a), tag_at(k), 32'(cur_lines()), 32'(exp_at(k, a)));
      end
      start_i = 1'b0;
   endtask

   task automatic run_plain(input logic [AW-1:0] a);
      while (busy_o) @(negedge clk);
      start_i = 1'b1; addr_i = a;
      exp_q.push_back(a);
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset levels
      chk(cur_lines() == 7'b0_0_0_0_0_1_1, "R1 reset idle levels", 32'(cur_lines()), 32'h03);

      run_traced(16'hA5C3, 0, '0);
      // R7 levels hold after completion
      repeat (20) @(negedge clk);
      chk(cur_lines() == 7'b0_0_0_0_0_1_0, "R7 enabled hold", 32'(cur_lines()), 32'h02);

      run_traced(16'h0000, 0, '0);
      run_traced(16'hFFFF, 0, '0);
      // R8 start mid-shift ignored
      run_traced(16'h8001, 50, 16'h7E7E);
      // R8 start in the done cycle ignored
      run_traced(16'h1234, K_DONE, 16'hBEEF);
      repeat (6) begin
         @(negedge clk);
         chk(!busy_o && !oe_n_o == 1'b1, "R8 no load after done-cycle start", 32'(cur_lines()), 32'h02);
      end

      // R9 reset mid-load aborts
      @(negedge clk);
      start_i = 1'b1; addr_i = 16'h5A5A;
      @(negedge clk);
      start_i = 1'b0;
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(cur_lines() == 7'b0_0_0_0_0_1_1, "R9 idle after abort", 32'(cur_lines()), 32'h03);
      begin
         bit seen_done;
         seen_done = 1'b0;
         repeat (120) begin
            @(negedge clk);
            if (done_o || busy_o) seen_done = 1'b1;
         end
         chk(!seen_done, "R9 no done after abort", 32'(seen_done), 32'h0);
      end

      // R8 back-to-back: start in first idle cycle is accepted
      for (int i = 0; i < 6; i++)
         run_plain(16'(((32'h1 << i) ^ (i * 32'h3B1)) & 32'hFFFF));
      run_traced(16'hC00D, 0, '0);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R10 all loads completed", 32'(exp_q.size()), 32'h0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule